// File: doc/BRIEF.md
# Histogram Memory Increment Engine

This block lets a sampling device, typically a converter, tally its own results in system memory with no processor involvement. Each sample value is taken as a word index, not as data: the engine joins it to a 5-bit field number to form a bus address, then increments the word stored there. It does this as a locked read, a one-cycle count step and a write-back. Over many samples the memory region becomes a histogram of the sample values.

Software sets up the engine through one control register. The register holds an enable bit and the field number that picks a 4K-word block of the 18-bit byte address space. The overrun status can be read back from the same register.

Samples enter on a valid/ready port. The engine keeps one pending sample while an operation is in progress. The device is a strobe source and cannot be stalled, so a sample offered while `dev_ready` is low is dropped and recorded in a sticky overrun flag. On the bus side the engine is a simple master: it holds `bus_req` and its qualifiers steady until the memory returns `bus_ack`.

Top module: `hist_incr_engine`

## Requirements
- R1: Each operation is a read request (`bus_we`=0) followed by a write request (`bus_we`=1) to the same address. Each request holds `bus_req`, `bus_we` and `bus_addr` steady until the cycle in which `bus_ack` is high. Exactly one idle-request cycle separates the read acknowledge from the write request.
- R2: The word written is the word read plus one, modulo 2^16. A read of 16'hFFFF is written back as 16'h0000.
- R3: `bus_addr` is {field[4:0], sample[11:0], 1'b0}. The field is the value held in the register when the operation leaves idle.
- R4: `bus_lock` is high from the first cycle of the read request through the cycle in which the write is acknowledged. It is low whenever no operation is in progress.
- R5: While the enable bit is clear, no new operation starts and `dev_ready` is low. Samples offered in that state are ignored and do not set overrun. An operation already started runs to completion, and a pending sample waits until the enable bit is set again.
- R6: `dev_ready` is high when the engine is enabled and either the pending slot is empty or its sample is being handed to the sequencer in that cycle. A handshake (`dev_valid` and `dev_ready` both high) stores the sample as the single pending request.
- R7: `stat_overrun` sets one cycle after `dev_valid` is high while the engine is enabled and `dev_ready` is low. It stays set until a control write clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: A control write (`ctl_wr` high) loads `ctl_enable` and `ctl_field`, and both appear on `stat_enable` and `stat_field` one cycle later.
- R9: After reset the engine is disabled, the field is 0, overrun is 0, no request or lock is asserted and `dev_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Enable value to load |
| ctl_field | input | 5 | Field number to load |
| stat_enable | output | 1 | Current enable bit |
| stat_field | output | 5 | Current field number |
| stat_overrun | output | 1 | Sticky dropped-sample flag |
| dev_valid | input | 1 | Sample offered |
| dev_ready | output | 1 | Sample slot can accept |
| dev_value | input | 12 | Sample used as word index |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_lock | output | 1 | Holds the bus across read and write |
| bus_addr | output | 18 | Byte address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Request accepted this cycle |
| bus_rdata | input | 16 | Read data, valid with the read acknowledge |

## Verification
A new sample can be accepted in the same cycle that the pending sample leaves the slot for the sequencer. In that cycle `dev_ready` must stay high and no overrun may be recorded. The bench provokes this with long runs of back-to-back strobes against a memory whose acknowledge delay varies at random. A behavioural reference, updated on every clock, decides whether each strobe was stored or dropped. `dev_ready`, `stat_overrun` and the bus outputs are compared against that reference on every cycle, and the final memory contents are compared against the expected per-address tallies. The bench also drives a control write in the same cycle as a refused strobe, to confirm that the set of the overrun flag wins over the clear.

// File: rtl/hie_pkg.sv
package hie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_BUMP  = 2'd2,
    ST_WRITE = 2'd3
  } hie_state_e;
endpackage

// File: rtl/hie_ctrl_reg.sv
module hie_ctrl_reg #(
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_enable,
  input  logic [FIELD_W-1:0] ctl_field,
  input  logic               ovr_event,
  output logic               enable,
  output logic [FIELD_W-1:0] field,
  output logic               overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      field   <= '0;
      overrun <= 1'b0;
    end else begin
      if (ctl_wr) begin
        enable <= ctl_enable;
        field  <= ctl_field;
      end
      if (ovr_event)   overrun <= 1'b1;
      else if (ctl_wr) overrun <= 1'b0;
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ctl_wr) |=> overrun); // R7
endmodule

// File: rtl/hie_req_slot.sv
module hie_req_slot #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  AST_SLOT_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |-> !push); // R6
endmodule

// File: rtl/hie_counter.sv
module hie_counter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              bump,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= din;
    else if (bump) count <= count + 1'b1;
  end
endmodule

// File: rtl/hie_bus_seq.sv
module hie_bus_seq
  import hie_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_lock,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              cnt_load,
  output logic              cnt_bump,
  output logic              idle
);
  hie_state_e state_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start) begin
                    addr_q  <= start_addr;
                    state_q <= ST_READ;
                  end
        ST_READ:  if (bus_ack) state_q <= ST_BUMP;
        ST_BUMP:  state_q <= ST_WRITE;
        ST_WRITE: if (bus_ack) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req  = (state_q == ST_READ) || (state_q == ST_WRITE);
    bus_we   = (state_q == ST_WRITE);
    bus_lock = (state_q != ST_IDLE);
    bus_addr = addr_q;
    cnt_load = (state_q == ST_READ) && bus_ack;
    cnt_bump = (state_q == ST_BUMP);
    idle     = (state_q == ST_IDLE);
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr))); // R1
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we) |=> !bus_req ##1 (bus_req && bus_we)); // R1
  AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_lock); // R4
  AST_LOCK_DROPS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_ack) |=> !bus_lock); // R4
endmodule

// File: rtl/hist_incr_engine.sv
module hist_incr_engine #(
  parameter int FIELD_W = 5,
  parameter int INDEX_W = 12,
  parameter int WORD_W  = 16,
  localparam int ADDR_W = FIELD_W + INDEX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_enable,
  input  logic [FIELD_W-1:0] ctl_field,
  output logic               stat_enable,
  output logic [FIELD_W-1:0] stat_field,
  output logic               stat_overrun,
  input  logic               dev_valid,
  output logic               dev_ready,
  input  logic [INDEX_W-1:0] dev_value,
  output logic               bus_req,
  output logic               bus_we,
  output logic               bus_lock,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [WORD_W-1:0]  bus_rdata
);
  logic               slot_full, seq_idle, push, pop, ovr_event;
  logic               cnt_load, cnt_bump;
  logic [INDEX_W-1:0] slot_value;
  logic [ADDR_W-1:0]  start_addr;

  assign pop        = seq_idle && slot_full && stat_enable;
  assign dev_ready  = stat_enable && (!slot_full || seq_idle);
  assign push       = dev_valid && dev_ready;
  assign ovr_event  = dev_valid && stat_enable && !dev_ready;
  assign start_addr = {stat_field, slot_value, 1'b0};

  hie_ctrl_reg #(.FIELD_W(FIELD_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_field(ctl_field), .ovr_event(ovr_event), .enable(stat_enable),
    .field(stat_field), .overrun(stat_overrun));

  hie_req_slot #(.DATA_W(INDEX_W)) i_slot (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(dev_value),
    .full(slot_full), .dout(slot_value));

  hie_bus_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(pop), .start_addr(start_addr),
    .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
    .bus_addr(bus_addr), .cnt_load(cnt_load), .cnt_bump(cnt_bump), .idle(seq_idle));

  hie_counter #(.WORD_W(WORD_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .bump(cnt_bump),
    .din(bus_rdata), .count(bus_wdata));

  // Checker state: word seen on the last read acknowledge
  logic [WORD_W-1:0] seen_rdata;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_rdata <= '0;
    else if (bus_req && !bus_we && bus_ack) seen_rdata <= bus_rdata;
  end

  AST_WRITE_IS_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == WORD_W'(seen_rdata + 1'b1))); // R2
  AST_ADDR_FROM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> ((bus_addr[ADDR_W-1 -: FIELD_W] == $past(stat_field)) && !bus_addr[0])); // R3
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> $past(stat_enable)); // R5
  AST_NO_READY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_enable |-> !dev_ready); // R5
endmodule

// File: tb/test_hist_incr_engine.sv
`timescale 1ns/1ps
module test_hist_incr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_enable = 1'b0;
  logic [4:0]  ctl_field = '0;
  logic        stat_enable, stat_overrun, dev_ready;
  logic [4:0]  stat_field;
  logic        dev_valid = 1'b0;
  logic [11:0] dev_value = '0;
  logic        bus_req, bus_we, bus_lock;
  logic [17:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #4 clk = ~clk;

  hist_incr_engine i_hist_incr_engine (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_field(ctl_field), .stat_enable(stat_enable), .stat_field(stat_field),
    .stat_overrun(stat_overrun), .dev_valid(dev_valid), .dev_ready(dev_ready),
    .dev_value(dev_value), .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory ----------------
  logic [15:0] mem [int];
  logic [15:0] exp_mem [int];
  function automatic logic [15:0] mem_rd(int k);
    if (mem.exists(k)) return mem[k];
    return 16'(k) ^ 16'h5A5A;
  endfunction

  int dly = 0;
  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (rst_n && bus_req) begin
      if (dly == 0) begin
        bus_ack = 1'b1;
        if (bus_we) mem[int'(bus_addr)] = bus_wdata;
        else        bus_rdata = mem_rd(int'(bus_addr));
        dly = $urandom % 4;
      end else dly--;
    end
  end

  // ---------------- reference model ----------------
  int          m_st;
  logic        m_en, m_ovr, m_full;
  logic [4:0]  m_field;
  logic [11:0] m_slot;
  logic [17:0] m_addr;
  logic [15:0] m_cnt;
  logic        r_rdy, r_pop, r_push;

  function automatic logic m_ready();
    return m_en && (!m_full || m_st == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_ovr = 0; m_full = 0;
      m_field = '0; m_slot = '0; m_addr = '0; m_cnt = '0;
    end else begin
      r_rdy  = m_ready();
      r_pop  = (m_st == 0) && m_full && m_en;
      r_push = dev_valid && r_rdy;
      if (dev_valid && m_en && !r_rdy) m_ovr = 1'b1;
      else if (ctl_wr)                 m_ovr = 1'b0;
      case (m_st)
        0: if (r_pop) begin
             int k;
             m_addr = {m_field, m_slot, 1'b0};
             k = int'(m_addr);
             exp_mem[k] = (exp_mem.exists(k) ? exp_mem[k] : mem_rd(k)) + 16'd1;
             m_st = 1;
           end
        1: if (bus_ack) begin m_cnt = bus_rdata; m_st = 2; end
        2: begin m_cnt = m_cnt + 16'd1; m_st = 3; end
        default: if (bus_ack) m_st = 0;
      endcase
      if (r_push)     begin m_slot = dev_value; m_full = 1'b1; end
      else if (r_pop) m_full = 1'b0;
      if (ctl_wr) begin m_en = ctl_enable; m_field = ctl_field; end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 dev_ready", dev_ready, m_ready());
      chk("R1 bus_req", bus_req, (m_st == 1 || m_st == 3));
      chk("R1 bus_we", bus_we & bus_req, (m_st == 3));
      chk("R4 bus_lock", bus_lock, (m_st != 0));
      if (m_st != 0) chk("R3 bus_addr", bus_addr, m_addr);
      if (m_st == 3) chk("R2 bus_wdata", bus_wdata, m_cnt);
      chk("R7 stat_overrun", stat_overrun, m_ovr);
      chk("R8 stat_enable", stat_enable, m_en);
      chk("R8 stat_field", stat_field, m_field);
    end
  end

  // ---------------- stimulus ----------------
  task automatic ctl_write(logic en, logic [4:0] f);
    @(negedge clk); ctl_wr = 1'b1; ctl_enable = en; ctl_field = f;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic strobe(logic [11:0] v);
    @(negedge clk); dev_valid = 1'b1; dev_value = v;
    @(negedge clk); dev_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (m_st == 0 && !m_full) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 enable", stat_enable, 1'b0);
    chk("R9 field", stat_field, 5'd0);
    chk("R9 overrun", stat_overrun, 1'b0);
    chk("R9 req/lock", {bus_req, bus_lock}, 2'b00);
    chk("R9 ready", dev_ready, 1'b0);

    // R5: strobes while disabled are ignored
    @(negedge clk); dev_valid = 1'b1; dev_value = 12'h123;
    repeat (3) @(negedge clk);
    dev_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 no lock when disabled", bus_lock, 1'b0);
    chk("R5 no overrun when disabled", stat_overrun, 1'b0);

    // R8: control write readback
    ctl_write(1'b1, 5'h03);
    chk("R8 enable readback", stat_enable, 1'b1);
    chk("R8 field readback", stat_field, 5'h03);

    // single spaced samples
    for (int i = 0; i < 8; i++) begin
      strobe(12'(i * 37 + 5));
      repeat ($urandom % 12) @(negedge clk);
    end
    drain();

    // R2: wrap to zero
    mem[int'({5'h03, 12'd7, 1'b0})] = 16'hFFFF;
    strobe(12'd7);
    drain();
    chk("R2 wrap writes zero", mem_rd(int'({5'h03, 12'd7, 1'b0})), 16'h0000);

    // R6/R7: back-to-back strobes, slot hand-off and overruns
    ctl_write(1'b1, 5'h11);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      dev_valid = 1'b1;
      for (int i = 0; i < 24; i++) begin
        dev_value = 12'($urandom % 8);
        @(negedge clk);
      end
      dev_valid = 1'b0;
      drain();
    end
    chk("R7 overrun seen", stat_overrun, 1'b1);
    ctl_write(1'b1, 5'h11);
    chk("R7 overrun cleared", stat_overrun, 1'b0);

    // R7: set wins over clear in the same cycle
    strobe(12'h040);
    @(negedge clk); dev_valid = 1'b1; dev_value = 12'h041;
    @(negedge clk); dev_value = 12'h042; ctl_wr = 1'b1; ctl_enable = 1'b1; ctl_field = 5'h11;
    @(negedge clk); dev_valid = 1'b0; ctl_wr = 1'b0;
    chk("R7 set wins", stat_overrun, 1'b1);
    drain();

    // R5: disable with a pending sample
    ctl_write(1'b1, 5'h1F);
    @(negedge clk); dev_valid = 1'b1; dev_value = 12'hFFF;
    @(negedge clk); dev_value = 12'h800;
    @(negedge clk); dev_valid = 1'b0; ctl_wr = 1'b1; ctl_enable = 1'b0; ctl_field = 5'h1F;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5 pending held while disabled", bus_lock, 1'b0);
    chk("R5 ready low while disabled", dev_ready, 1'b0);
    ctl_write(1'b1, 5'h1F);
    drain();

    // histogram contents
    foreach (exp_mem[k]) chk("R2 histogram word", mem_rd(k), exp_mem[k]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule